// File: doc/BRIEF.md
# Debug Command Engine

This block runs the hardware-level commands of a background debug port. A deserialiser in front of it hands over whole bytes. The first byte is an 8-bit opcode, and the two bytes after it are a big-endian 16-bit address when the command needs one. The engine turns each read command into at most one access on an internal 16-bit read bus and returns a 16-bit result with a one-cycle completion strobe. It holds two mode flags: one says that entry to background mode is allowed, and the other says that background mode is active. Bringing the engine out of reset with the special strap set raises both flags at once.

While background mode is active, a read with the overlay mapped in sees seven debug register bytes and a debug ROM window, and no bus access takes place. The status byte can be read through the overlay at any time. The engine keeps a fixed spacing between the last byte of a command and its completion. This lets the host time its next command by counting cycles. A stall output marks every bus access that needs more than one cycle.

Top module: `dbg_cmd_engine`

## Requirements
- R1: After reset, with `special_mode_i`=1 both `active_o` and `enabled_o` are 1, and with `special_mode_i`=0 both are 0. In both cases `busy_o`, `done_o` and `bus_req_o` are 0.
- R2: Opcode 0xE4 at address 0xFF01 returns a status byte in the low lane, with no bus access. The status byte is 0xC0 when active, else 0x80 when enabled, else 0x00.
- R3: Opcode 0x90 sets a pending entry only while enabled. The pending entry raises `active_o` on the clock edge that samples `insn_boundary_i`=1. A 0x90 received while disabled has no effect.
- R4: On a byte read, an odd address places its byte in result[7:0] with result[15:8]=0. An even address places it in result[15:8] with result[7:0]=0. A bus access always uses the even address and returns bus_rdata[15:8] for the even byte and bus_rdata[7:0] for the odd byte.
- R5: Opcode 0xE0 reads a byte over the bus for every address, including 0xFF00–0xFFFF.
- R6: While active, opcode 0xE4 answers 0xFF00–0xFF06 from the registers and 0xFF20–0xFFFF from the ROM, with no bus access. The register at 0xFF01 holds the status and the others read 0x00. A ROM byte equals the low address byte XOR 0x5A. While not active, these addresses, except 0xFF01, go to the bus.
- R7: Opcode 0xEC with an even address returns a word. It comes from the bus, or while active from the overlay, with the even byte in [15:8]. The word at 0xFF06 reads 0x00 in its low byte.
- R8: Opcode 0xEC with an odd address completes with `err_o`=1 and result 0x0000, and it issues no bus access. `err_o` is 0 after every other command.
- R9: `done_o` pulses exactly GAP_CYCLES cycles after the clock edge that accepted the last byte of the command, as long as the bus answers in time. Bytes that arrive while `busy_o`=1 are dropped.
- R10: A bus access acknowledged in its first request cycle raises no stall. Otherwise `bus_req_o` holds and `stall_o` is 1 from the second request cycle until the acknowledge cycle, that is, for one cycle per wait cycle.
- R11: An opcode other than 0x90, 0xE0, 0xE4 or 0xEC is dropped. The engine stays idle with `busy_o`=0.
- R12: `busy_o` is 1 from the cycle after the opcode is accepted until the result is valid. It is 0 in the cycle where `done_o`=1.
- R13: `en_set_i` sets the enable flag and `en_clr_i` clears it, with clear taking priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| special_mode_i | input | 1 | Strap: start active and enabled |
| byte_valid_i | input | 1 | Host byte strobe |
| byte_i | input | 8 | Host byte |
| en_set_i | input | 1 | Set the enable flag |
| en_clr_i | input | 1 | Clear the enable flag |
| insn_boundary_i | input | 1 | CPU instruction boundary |
| bus_req_o | output | 1 | Read request, held until acknowledged |
| bus_addr_o | output | 16 | Even word address |
| bus_ack_i | input | 1 | Read data valid |
| bus_rdata_i | input | 16 | Read data |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Result valid, one cycle |
| result_o | output | 16 | Command result, held |
| err_o | output | 1 | Misaligned word read |
| stall_o | output | 1 | Multi-cycle access in progress |
| active_o | output | 1 | Background mode active |
| enabled_o | output | 1 | Background entry allowed |

## Verification
Two things can overlap: a host byte arriving while an earlier command is still counting out its spacing, and a bus access stretching into stall cycles inside that same window. The bench sends a stray 0x90 in the middle of a status read while enabled, then pulses an instruction boundary. It confirms that the next status read still returns 0x0080. It also runs a word read whose bus acknowledge comes late and counts the stall cycles. It checks that completion still lands exactly GAP_CYCLES cycles after the address.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

  localparam logic [7:0] OP_BGND     = 8'h90;
  localparam logic [7:0] OP_BYTE_OV  = 8'hE4;
  localparam logic [7:0] OP_WORD_OV  = 8'hEC;
  localparam logic [7:0] OP_BYTE_RAW = 8'hE0;

  localparam logic [15:0] STATUS_ADDR = 16'hFF01;

  typedef enum logic [2:0] {
    S_IDLE, S_AHI, S_ALO, S_LAUNCH, S_WAIT, S_DONE
  } seq_e;

  typedef enum logic [1:0] {
    K_BGND, K_BYTE_OV, K_BYTE_RAW, K_WORD_OV
  } kind_e;

  function automatic logic [7:0] status_byte(input logic active, input logic enabled);
    if (active)       return 8'hC0;
    else if (enabled) return 8'h80;
    else              return 8'h00;
  endfunction

  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [15:0] place_byte(input logic odd, input logic [7:0] b);
    return odd ? {8'h00, b} : {b, 8'h00};
  endfunction

  function automatic logic in_regs(input logic [15:0] a);
    return (a[15:3] == 13'h1FE0) && (a[2:0] != 3'd7);
  endfunction

  function automatic logic in_rom(input logic [15:0] a);
    return (a[15:8] == 8'hFF) && (a[7:5] != 3'd0);
  endfunction

endpackage

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic special_mode_i,
  input  logic en_set_i,
  input  logic en_clr_i,
  input  logic bgnd_req_i,
  input  logic insn_boundary_i,
  output logic active_o,
  output logic enabled_o,
  output logic pending_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled_o <= special_mode_i;
      active_o  <= special_mode_i;
      pending_o <= 1'b0;
    end else begin
      if (en_clr_i)      enabled_o <= 1'b0;
      else if (en_set_i) enabled_o <= 1'b1;

      if (pending_o && insn_boundary_i) begin
        active_o  <= 1'b1;
        pending_o <= 1'b0;
      end else if (bgnd_req_i && enabled_o && !active_o) begin
        pending_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbg_overlay_map.sv
module dbg_overlay_map
  import dbg_cmd_pkg::*;
(
  input  logic [15:0] addr_i,
  input  logic        overlay_i,
  input  logic        word_i,
  input  logic        active_i,
  input  logic [7:0]  status_i,
  output logic        hit_o,
  output logic [15:0] data_o
);
  logic [15:0] addr_odd;
  logic [7:0]  byte_lo, byte_hi;

  function automatic logic [7:0] overlay_byte(input logic [15:0] a, input logic [7:0] st);
    if (a == STATUS_ADDR) return st;
    else if (in_rom(a))   return rom_byte(a);
    else                  return 8'h00;
  endfunction

  assign addr_odd = {addr_i[15:1], 1'b1};
  assign byte_hi  = overlay_byte({addr_i[15:1], 1'b0}, status_i);
  assign byte_lo  = overlay_byte(addr_odd, status_i);

  always_comb begin
    if (word_i) begin
      hit_o  = overlay_i && active_i && (in_regs(addr_i) || in_rom(addr_i));
      data_o = {byte_hi, byte_lo};
    end else begin
      hit_o  = overlay_i && ((addr_i == STATUS_ADDR) ||
                             (active_i && (in_regs(addr_i) || in_rom(addr_i))));
      data_o = place_byte(addr_i[0], overlay_byte(addr_i, status_i));
    end
  end
endmodule

// File: rtl/dbg_bus_port.sv
module dbg_bus_port #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  output logic          bus_req_o,
  output logic [AW-1:0] bus_addr_o,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          stall_o
);
  logic waited;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_req_o  <= 1'b0;
      bus_addr_o <= '0;
      rdata_o    <= '0;
      waited     <= 1'b0;
    end else if (start_i) begin
      bus_req_o  <= 1'b1;
      bus_addr_o <= {addr_i[AW-1:1], 1'b0};
      waited     <= 1'b0;
    end else if (bus_req_o) begin
      if (bus_ack_i) begin
        bus_req_o <= 1'b0;
        rdata_o   <= bus_rdata_i;
        waited    <= 1'b0;
      end else begin
        waited    <= 1'b1;
      end
    end
  end

  assign stall_o = bus_req_o && waited;
endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine
  import dbg_cmd_pkg::*;
#(
  parameter int GAP_CYCLES = 150
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        special_mode_i,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  input  logic        en_set_i,
  input  logic        en_clr_i,
  input  logic        insn_boundary_i,
  output logic        bus_req_o,
  output logic [15:0] bus_addr_o,
  input  logic        bus_ack_i,
  input  logic [15:0] bus_rdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] result_o,
  output logic        err_o,
  output logic        stall_o,
  output logic        active_o,
  output logic        enabled_o
);
  localparam int GW = $clog2(GAP_CYCLES + 1);

  seq_e          state;
  kind_e         kind;
  logic [15:0]   addr_q;
  logic [GW-1:0] gap_cnt;
  logic          hit_q;
  logic [15:0]   ovl_q;

  // named internal events
  logic        take_op;
  logic        op_known;
  logic        op_unknown;
  logic        bgnd_req;
  logic        launch;
  logic        launch_bad;
  logic        bus_start;
  logic        finish;
  logic        bgnd_pending;
  logic        map_hit;
  logic [15:0] map_data;
  logic [15:0] bus_data;
  logic [15:0] result_next;

  assign take_op    = (state == S_IDLE) && byte_valid_i;
  assign op_known   = (byte_i == OP_BGND) || (byte_i == OP_BYTE_OV) ||
                      (byte_i == OP_WORD_OV) || (byte_i == OP_BYTE_RAW);
  assign op_unknown = take_op && !op_known;
  assign bgnd_req   = take_op && (byte_i == OP_BGND);
  assign launch     = (state == S_LAUNCH);
  assign launch_bad = launch && (kind == K_WORD_OV) && addr_q[0];
  assign bus_start  = launch && !launch_bad && !map_hit;
  assign finish     = (state == S_WAIT) && (gap_cnt == '0) && !bus_req_o;

  dbg_mode_ctrl u_mode (
    .clk             (clk),
    .rst_n           (rst_n),
    .special_mode_i  (special_mode_i),
    .en_set_i        (en_set_i),
    .en_clr_i        (en_clr_i),
    .bgnd_req_i      (bgnd_req),
    .insn_boundary_i (insn_boundary_i),
    .active_o        (active_o),
    .enabled_o       (enabled_o),
    .pending_o       (bgnd_pending)
  );

  dbg_overlay_map u_map (
    .addr_i    (addr_q),
    .overlay_i (kind != K_BYTE_RAW),
    .word_i    (kind == K_WORD_OV),
    .active_i  (active_o),
    .status_i  (status_byte(active_o, enabled_o)),
    .hit_o     (map_hit),
    .data_o    (map_data)
  );

  dbg_bus_port #(.AW(16), .DW(16)) u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (bus_start),
    .addr_i      (addr_q),
    .bus_req_o   (bus_req_o),
    .bus_addr_o  (bus_addr_o),
    .bus_ack_i   (bus_ack_i),
    .bus_rdata_i (bus_rdata_i),
    .rdata_o     (bus_data),
    .stall_o     (stall_o)
  );

  always_comb begin
    if (kind == K_BGND)                  result_next = 16'h0000;
    else if (kind == K_WORD_OV && addr_q[0]) result_next = 16'h0000;
    else if (hit_q)                      result_next = ovl_q;
    else if (kind == K_WORD_OV)          result_next = bus_data;
    else result_next = place_byte(addr_q[0], addr_q[0] ? bus_data[7:0] : bus_data[15:8]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      kind     <= K_BGND;
      addr_q   <= '0;
      gap_cnt  <= '0;
      hit_q    <= 1'b0;
      ovl_q    <= '0;
      result_o <= '0;
      err_o    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (byte_valid_i) begin
          case (byte_i)
            OP_BGND: begin
              kind    <= K_BGND;
              hit_q   <= 1'b0;
              gap_cnt <= GW'(GAP_CYCLES - 1);
              state   <= S_WAIT;
            end
            OP_BYTE_OV:  begin kind <= K_BYTE_OV;  state <= S_AHI; end
            OP_BYTE_RAW: begin kind <= K_BYTE_RAW; state <= S_AHI; end
            OP_WORD_OV:  begin kind <= K_WORD_OV;  state <= S_AHI; end
            default: state <= S_IDLE;
          endcase
        end
        S_AHI: if (byte_valid_i) begin
          addr_q[15:8] <= byte_i;
          state        <= S_ALO;
        end
        S_ALO: if (byte_valid_i) begin
          addr_q[7:0] <= byte_i;
          gap_cnt     <= GW'(GAP_CYCLES - 1);
          state       <= S_LAUNCH;
        end
        S_LAUNCH: begin
          hit_q <= map_hit && !launch_bad;
          ovl_q <= map_data;
          if (gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
          state <= S_WAIT;
        end
        S_WAIT: begin
          if (gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
          if (finish) begin
            result_o <= result_next;
            err_o    <= (kind == K_WORD_OV) && addr_q[0];
            state    <= S_DONE;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (state != S_IDLE) && (state != S_DONE);
  assign done_o = (state == S_DONE);
endmodule

// File: rtl/dbg_cmd_engine_chk.sv
module dbg_cmd_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic done_o,
  input logic busy_o,
  input logic stall_o,
  input logic bus_req_o,
  input logic bus_ack_i,
  input logic active_o,
  input logic insn_boundary_i,
  input logic bgnd_pending,
  input logic launch_bad,
  input logic op_unknown
);
  // R10: a stall is only shown while a request is outstanding
  p_stall_in_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> bus_req_o);

  // R10: an unanswered request is held
  p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_ack_i) |=> bus_req_o);

  // R8: a misaligned word read never reaches the bus
  p_no_bus_misalign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    launch_bad |=> !bus_req_o);

  // R12: completion and busy never overlap, and busy only ends with completion
  p_done_not_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_busy_ends_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R9: completion is a single-cycle strobe
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3: activation needs a pending entry and an instruction boundary
  p_active_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> ($past(insn_boundary_i) && $past(bgnd_pending)));

  // R11: an unknown opcode leaves the engine idle
  p_unknown_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_unknown |=> !busy_o);
endmodule

bind dbg_cmd_engine dbg_cmd_engine_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .done_o          (done_o),
  .busy_o          (busy_o),
  .stall_o         (stall_o),
  .bus_req_o       (bus_req_o),
  .bus_ack_i       (bus_ack_i),
  .active_o        (active_o),
  .insn_boundary_i (insn_boundary_i),
  .bgnd_pending    (bgnd_pending),
  .launch_bad      (launch_bad),
  .op_unknown      (op_unknown)
);

// File: tb/tb_dbg_cmd_engine.sv
module tb_dbg_cmd_engine;
  localparam int GAP = 150;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        special_mode_i = 1'b0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_i = 8'h00;
  logic        en_set_i = 1'b0;
  logic        en_clr_i = 1'b0;
  logic        insn_boundary_i = 1'b0;
  logic        bus_req_o;
  logic [15:0] bus_addr_o;
  logic        bus_ack_i = 1'b0;
  logic [15:0] bus_rdata_i = 16'h0000;
  logic        busy_o, done_o, err_o, stall_o, active_o, enabled_o;
  logic [15:0] result_o;

  dbg_cmd_engine #(.GAP_CYCLES(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .special_mode_i(special_mode_i),
    .byte_valid_i(byte_valid_i), .byte_i(byte_i),
    .en_set_i(en_set_i), .en_clr_i(en_clr_i), .insn_boundary_i(insn_boundary_i),
    .bus_req_o(bus_req_o), .bus_addr_o(bus_addr_o), .bus_ack_i(bus_ack_i),
    .bus_rdata_i(bus_rdata_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .err_o(err_o), .stall_o(stall_o),
    .active_o(active_o), .enabled_o(enabled_o)
  );

  always #10 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int last_cyc = 0;
  int lat     = 0;
  int wait_cnt = 0;
  int bus_cnt = 0;
  int stall_cnt = 0;
  logic req_prev = 1'b0;

  typedef struct {
    logic [15:0] res;
    logic        err;
    int          nbus;
    int          nstall;
    string       tag;
  } exp_t;
  exp_t sb[$];

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8] ^ 8'hC3};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // bus model: acknowledge after lat wait cycles
  always @(negedge clk) begin
    if (bus_req_o) begin
      if (wait_cnt >= lat) begin
        bus_ack_i   <= 1'b1;
        bus_rdata_i <= mem_word(bus_addr_o);
      end else begin
        bus_ack_i <= 1'b0;
        wait_cnt  <= wait_cnt + 1;
      end
    end else begin
      bus_ack_i <= 1'b0;
      wait_cnt  <= 0;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_req_o && !req_prev) bus_cnt++;
      if (stall_o) stall_cnt++;
      req_prev <= bus_req_o;
      if (done_o) begin
        if (sb.size() == 0) begin
          check(1'b0, "R11 unexpected completion", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(result_o == e.res, {e.tag, " result"}, result_o, e.res);
          check(err_o == e.err, "R8 error flag", err_o, e.err);
          check(bus_cnt == e.nbus, {e.tag, " bus accesses"}, bus_cnt, e.nbus);
          check(stall_cnt == e.nstall, "R10 stall cycles", stall_cnt, e.nstall);
          check(cyc - last_cyc == GAP, "R9 spacing", cyc - last_cyc, GAP);
          check(!busy_o, "R12 busy at done", busy_o, 0);
        end
        bus_cnt   = 0;
        stall_cnt = 0;
      end
    end else begin
      req_prev  <= 1'b0;
      bus_cnt   = 0;
      stall_cnt = 0;
    end
  end

  task automatic send_byte(input logic [7:0] b, input bit mark);
    @(negedge clk);
    byte_valid_i = 1'b1;
    byte_i       = b;
    @(negedge clk);
    if (mark) last_cyc = cyc;
    byte_valid_i = 1'b0;
  endtask

  task automatic wait_empty();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [15:0] res, input logic err, input int nbus,
                      input int nstall, input string tag);
    exp_t e;
    e.res = res; e.err = err; e.nbus = nbus; e.nstall = nstall; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic issue(input logic [7:0] op, input logic [15:0] a);
    send_byte(op, op == 8'h90);
    check(busy_o == 1'b1, "R12 busy after opcode", busy_o, 1);
    if (op != 8'h90) begin
      send_byte(a[15:8], 1'b0);
      send_byte(a[7:0], 1'b1);
    end
  endtask

  task automatic cmd(input logic [7:0] op, input logic [15:0] a, input logic [15:0] res,
                     input logic err, input int nbus, input int nstall, input string tag);
    push(res, err, nbus, nstall, tag);
    issue(op, a);
    wait_empty();
  endtask

  task automatic pulse_boundary();
    @(negedge clk); insn_boundary_i = 1'b1;
    @(negedge clk); insn_boundary_i = 1'b0;
  endtask

  task automatic do_reset(input logic sp);
    @(negedge clk);
    rst_n = 1'b0;
    special_mode_i = sp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(active_o == sp, "R1 active after reset", active_o, sp);
    check(enabled_o == sp, "R1 enabled after reset", enabled_o, sp);
    check(!busy_o && !done_o && !bus_req_o, "R1 idle after reset",
          {busy_o, done_o, bus_req_o}, 0);
  endtask

  initial begin
    do_reset(1'b0);

    // not active, not enabled
    cmd(8'hE4, 16'hFF01, 16'h0000, 1'b0, 0, 0, "R2 status idle");
    cmd(8'hE4, 16'hFF20, 16'h1C00, 1'b0, 1, 0, "R6 rom hidden when inactive");
    cmd(8'h90, 16'h0000, 16'h0000, 1'b0, 0, 0, "R3 bgnd while disabled");
    pulse_boundary();
    check(active_o == 1'b0, "R3 disabled entry ignored", active_o, 0);

    // enable flag
    @(negedge clk); en_set_i = 1'b1; en_clr_i = 1'b1;
    @(negedge clk); en_set_i = 1'b0; en_clr_i = 1'b0;
    check(enabled_o == 1'b0, "R13 clear has priority", enabled_o, 0);
    @(negedge clk); en_set_i = 1'b1;
    @(negedge clk); en_set_i = 1'b0;
    check(enabled_o == 1'b1, "R13 set", enabled_o, 1);
    cmd(8'hE4, 16'hFF01, 16'h0080, 1'b0, 0, 0, "R2 status enabled");

    // stray opcode while busy
    push(16'h0080, 1'b0, 0, 0, "R9 status with stray byte");
    issue(8'hE4, 16'hFF01);
    send_byte(8'h90, 1'b0);
    wait_empty();
    pulse_boundary();
    check(active_o == 1'b0, "R9 byte during busy dropped", active_o, 0);
    cmd(8'hE4, 16'hFF01, 16'h0080, 1'b0, 0, 0, "R9 status unchanged");

    // background entry
    cmd(8'h90, 16'h0000, 16'h0000, 1'b0, 0, 0, "R3 bgnd accepted");
    check(active_o == 1'b0, "R3 waits for boundary", active_o, 0);
    pulse_boundary();
    check(active_o == 1'b1, "R3 active at boundary", active_o, 1);
    cmd(8'hE4, 16'hFF01, 16'h00C0, 1'b0, 0, 0, "R2 status active");

    // overlay reads
    cmd(8'hE4, 16'hFF20, 16'h7A00, 1'b0, 0, 0, "R6 rom even");
    cmd(8'hE4, 16'hFF21, 16'h007B, 1'b0, 0, 0, "R6 rom odd");
    cmd(8'hE4, 16'hFF03, 16'h0000, 1'b0, 0, 0, "R6 register");
    cmd(8'hEC, 16'hFF20, 16'h7A7B, 1'b0, 0, 0, "R7 rom word");
    cmd(8'hEC, 16'hFF00, 16'h00C0, 1'b0, 0, 0, "R7 register word");
    cmd(8'hEC, 16'hFF06, 16'h0000, 1'b0, 0, 0, "R7 last register word");

    // overlay mapped out and plain bus reads
    cmd(8'hE0, 16'hFF01, 16'h003C, 1'b0, 1, 0, "R5 raw read bypasses overlay");
    cmd(8'hE4, 16'h1234, 16'h0800, 1'b0, 1, 0, "R4 even lane");
    cmd(8'hE4, 16'h1235, 16'h00D1, 1'b0, 1, 0, "R4 odd lane");
    cmd(8'hEC, 16'h1234, 16'h08D1, 1'b0, 1, 0, "R7 bus word");
    cmd(8'hEC, 16'h1235, 16'h0000, 1'b1, 0, 0, "R8 misaligned word");

    lat = 4;
    cmd(8'hEC, 16'h1234, 16'h08D1, 1'b0, 1, 4, "R10 slow bus word");
    lat = 0;

    // unknown opcode
    send_byte(8'h55, 1'b0);
    check(busy_o == 1'b0, "R11 unknown opcode idle", busy_o, 1'b0);
    repeat (5) @(negedge clk);
    check(busy_o == 1'b0, "R11 still idle", busy_o, 1'b0);
    cmd(8'hE4, 16'h1235, 16'h00D1, 1'b0, 1, 0, "R11 next command normal");

    // special strap
    do_reset(1'b1);
    cmd(8'hE4, 16'hFF01, 16'h00C0, 1'b0, 0, 0, "R1 status after special reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule